// File: doc/BRIEF.md
# Ethernet Multicast Hash Filter

This block makes the address-acceptance decision for a receive MAC. The six destination-address bytes of an incoming frame arrive one per strobed cycle, first byte first. While they stream in, the block runs the Ethernet CRC-32 across them and keeps a copy of the full address.

After the sixth byte, the block combines four things into one accept/reject result:
- the three mode inputs (promiscuous, accept-any-multicast and accept-hashed-multicast);
- a 64-bin hash table, indexed by the top six bits of that CRC;
- an exact compare against a 48-bit station address;
- a broadcast check.

The result is registered and comes with a one-cycle done pulse. Frame storage, FCS checking and the rest of the MAC sit outside the block.

Software loads the hash table by setting the bin that each wanted group address hashes to. A multicast frame whose bin is set is then passed. A frame whose bin is clear is dropped, unless a wider mode is on.

Top module: `mcast_hash_filter`

## Requirements
- R1: While rst_ni is low and in the first cycle after it rises, done_o and accept_o are 0.
- R2: done_o is high for exactly one cycle, starting in the cycle after the clock edge that takes the sixth strobed byte. Cycles with byte_valid_i low are ignored whatever byte_i holds, and a reset discards a partly received address.
- R3: With promisc_i set, every address is accepted.
- R4: The broadcast address (all 48 bits one) is always accepted, whatever the mode inputs and table hold.
- R5: A unicast address is accepted, outside promiscuous mode, only when it equals station_addr_i exactly. The first received byte is compared with station_addr_i[47:40] and the sixth with station_addr_i[7:0].
- R6: An address is multicast when bit 0 of its first received byte is 1.
- R7: With all_mcast_i set, every multicast address is accepted regardless of hash_table_i.
- R8: With hash_mcast_i set, a multicast address is accepted when hash_table_i[idx] is 1. Here idx is bits 31:26 of a CRC-32 with these properties:
  - polynomial 0x04C11DB7;
  - register preset to all ones;
  - bytes taken in received order, each byte LSB first;
  - no final inversion.
- R9: A non-broadcast multicast address is rejected when promisc_i, all_mcast_i and hash_mcast_i are all 0, even if its table bin is 1.
- R10: accept_o keeps its value in every cycle in which done_o is low.
- R11: The mode inputs, hash_table_i and station_addr_i are used as they stand in the cycle of the sixth byte. Their values during earlier bytes and after the decision have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_valid_i | input | 1 | Strobe: byte_i carries the next address byte |
| byte_i | input | 8 | Destination address byte, first byte first |
| promisc_i | input | 1 | Accept every frame |
| all_mcast_i | input | 1 | Accept every multicast frame |
| hash_mcast_i | input | 1 | Accept multicast frames whose hash bin is set |
| hash_table_i | input | 64 | Hash bins, bit n is bin n |
| station_addr_i | input | 48 | Station address, first byte in bits 47:40 |
| done_o | output | 1 | One-cycle pulse: accept_o holds a new decision |
| accept_o | output | 1 | Last decision, 1 = accept |

## Verification
The assertions assume two things about the inputs. First, frame boundaries are implied purely by counting strobes, so each address arrives as exactly six strobed bytes. Second, the controls are meaningful in the sixth-byte cycle. The stimulus keeps to this by sending whole addresses and by resetting before any fresh address whenever it deliberately abandons one part-way. Where the stimulus varies the mode inputs inside a frame, it does so only to show that earlier values are disregarded. The broadcast and promiscuous checks hold for any table contents, so the bench sweeps the table through empty, single-bin, all-but-one and full patterns.

// File: rtl/mhf_pkg.sv
package mhf_pkg;
  typedef struct packed {
    logic promisc;
    logic all_mcast;
    logic hash_mcast;
  } mhf_mode_t;

  localparam logic [31:0] ETH_CRC_POLY = 32'h04C1_1DB7;
endpackage

// File: rtl/mhf_crc_unit.sv
module mhf_crc_unit #(
  parameter int          CRC_W  = 32,
  parameter int          DATA_W = 8,
  parameter logic [CRC_W-1:0] POLY = 32'h04C1_1DB7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              restart_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [CRC_W-1:0]  crc_next_o
);
  logic [CRC_W-1:0] crc_q;

  // serial LSB-first update, unrolled over one byte
  always_comb begin
    logic [CRC_W-1:0] c;
    logic             fb;
    c = restart_i ? {CRC_W{1'b1}} : crc_q;
    for (int i = 0; i < DATA_W; i++) begin
      fb = c[CRC_W-1] ^ data_i[i];
      c  = {c[CRC_W-2:0], 1'b0};
      if (fb) c = c ^ POLY;
    end
    crc_next_o = c;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   crc_q <= {CRC_W{1'b1}};
    else if (en_i) crc_q <= crc_next_o;
  end
endmodule

// File: rtl/mhf_addr_shift.sv
module mhf_addr_shift #(
  parameter int N_BYTES = 6,
  localparam int ADDR_W = N_BYTES * 8,
  localparam int CNT_W  = (N_BYTES > 1) ? $clog2(N_BYTES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [7:0]        byte_i,
  output logic              first_o,
  output logic              last_o,
  output logic [ADDR_W-1:0] addr_next_o
);
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] addr_q;

  assign first_o = (cnt_q == '0);
  assign last_o  = (cnt_q == CNT_W'(N_BYTES - 1));

  generate
    if (N_BYTES > 1) begin : g_multi
      assign addr_next_o = {addr_q[ADDR_W-9:0], byte_i};
    end else begin : g_single
      assign addr_next_o = byte_i;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      addr_q <= '0;
    end else if (valid_i) begin
      addr_q <= addr_next_o;
      cnt_q  <= last_o ? '0 : cnt_q + 1'b1;
    end
  end

  // R2
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(N_BYTES - 1));

  // R2
  cnt_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(cnt_q));
endmodule

// File: rtl/mhf_decide.sv
module mhf_decide
  import mhf_pkg::*;
#(
  parameter int N_BYTES   = 6,
  parameter int HASH_BITS = 6,
  localparam int ADDR_W  = N_BYTES * 8,
  localparam int TABLE_W = 1 << HASH_BITS
) (
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [ADDR_W-1:0]    station_i,
  input  logic [TABLE_W-1:0]   table_i,
  input  logic [HASH_BITS-1:0] hash_idx_i,
  input  mhf_mode_t            mode_i,
  output logic                 accept_o
);
  logic group_addr, bcast, ucast_hit, bin_hit;

  // group bit: bit 0 of the first byte on the wire
  assign group_addr = addr_i[ADDR_W-8];
  assign bcast      = &addr_i;
  assign ucast_hit  = (addr_i == station_i);
  assign bin_hit    = table_i[hash_idx_i];

  always_comb begin
    if (mode_i.promisc || bcast)
      accept_o = 1'b1;
    else if (group_addr)
      accept_o = mode_i.all_mcast || (mode_i.hash_mcast && bin_hit);
    else
      accept_o = ucast_hit;
  end
endmodule

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter
  import mhf_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_BITS  = 6,
  parameter int CRC_W      = 32,
  parameter logic [CRC_W-1:0] CRC_POLY = ETH_CRC_POLY,
  localparam int ADDR_W  = ADDR_BYTES * 8,
  localparam int TABLE_W = 1 << HASH_BITS
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               byte_valid_i,
  input  logic [7:0]         byte_i,
  input  logic               promisc_i,
  input  logic               all_mcast_i,
  input  logic               hash_mcast_i,
  input  logic [TABLE_W-1:0] hash_table_i,
  input  logic [ADDR_W-1:0]  station_addr_i,
  output logic               done_o,
  output logic               accept_o
);
  logic              first_b, last_b, decision;
  logic [ADDR_W-1:0] addr_next;
  logic [CRC_W-1:0]  crc_next;
  mhf_mode_t         mode;

  assign mode = '{promisc: promisc_i, all_mcast: all_mcast_i, hash_mcast: hash_mcast_i};

  mhf_addr_shift #(.N_BYTES(ADDR_BYTES)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_i     (byte_valid_i),
    .byte_i      (byte_i),
    .first_o     (first_b),
    .last_o      (last_b),
    .addr_next_o (addr_next)
  );

  mhf_crc_unit #(.CRC_W(CRC_W), .DATA_W(8), .POLY(CRC_POLY)) u_crc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (byte_valid_i),
    .restart_i  (first_b),
    .data_i     (byte_i),
    .crc_next_o (crc_next)
  );

  mhf_decide #(.N_BYTES(ADDR_BYTES), .HASH_BITS(HASH_BITS)) u_decide (
    .addr_i     (addr_next),
    .station_i  (station_addr_i),
    .table_i    (hash_table_i),
    .hash_idx_i (crc_next[CRC_W-1 -: HASH_BITS]),
    .mode_i     (mode),
    .accept_o   (decision)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o   <= 1'b0;
      accept_o <= 1'b0;
    end else begin
      done_o <= byte_valid_i && last_b;
      if (byte_valid_i && last_b) accept_o <= decision;
    end
  end

  // R2
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R3
  promisc_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_i && last_b && promisc_i) |=> (done_o && accept_o));

  // R4
  bcast_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_i && last_b && (&addr_next)) |=> accept_o);

  // R5
  ucast_miss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_i && last_b && !promisc_i && !addr_next[ADDR_W-8]
     && addr_next != station_addr_i) |=> !accept_o);

  // R9
  mcast_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_i && last_b && addr_next[ADDR_W-8] && !(&addr_next)
     && !promisc_i && !all_mcast_i && !hash_mcast_i) |=> !accept_o);

  // R10
  accept_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(accept_o));
endmodule

// File: tb/tb_mcast_hash_filter.sv
`timescale 1ns/1ps
module tb_mcast_hash_filter;
  localparam logic [47:0] STA  = 48'h0250_A1B2_C3D4;
  localparam logic [47:0] GRP  = 48'h0100_5E00_0001;
  localparam logic [47:0] GRP6 = 48'h3333_0000_0001;
  localparam logic [47:0] BC   = 48'hFFFF_FFFF_FFFF;
  localparam logic [31:0] POLY = 32'h04C1_1DB7;

  typedef struct packed {
    logic [47:0] addr;
    logic        pr;
    logic        am;
    logic        hm;
    logic [1:0]  tsel; // 0 empty, 1 own bin only, 2 all but own bin, 3 full
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{STA,                 1'b0, 1'b0, 1'b0, 2'd0, 4'd5}, // R5 exact hit
    '{STA ^ 48'h1,         1'b0, 1'b0, 1'b0, 2'd0, 4'd5}, // R5 last byte differs
    '{48'hD4C3_B2A1_5002,  1'b0, 1'b0, 1'b0, 2'd3, 4'd5}, // R5 byte order reversed
    '{48'h0A0B_0C0D_0E0F,  1'b1, 1'b0, 1'b0, 2'd0, 4'd3}, // R3 unicast miss, promisc
    '{GRP,                 1'b1, 1'b0, 1'b0, 2'd0, 4'd3}, // R3 multicast, promisc
    '{BC,                  1'b0, 1'b0, 1'b0, 2'd0, 4'd4}, // R4 no modes
    '{BC,                  1'b0, 1'b0, 1'b1, 2'd2, 4'd4}, // R4 hash mode, bin clear
    '{GRP,                 1'b0, 1'b0, 1'b0, 2'd3, 4'd9}, // R9 full table, no mode
    '{GRP,                 1'b0, 1'b1, 1'b0, 2'd0, 4'd7}, // R7 empty table
    '{GRP,                 1'b0, 1'b0, 1'b1, 2'd1, 4'd8}, // R8 own bin only
    '{GRP,                 1'b0, 1'b0, 1'b1, 2'd2, 4'd8}, // R8 all but own bin
    '{GRP6,                1'b0, 1'b0, 1'b1, 2'd1, 4'd8}, // R8 second group, bin set
    '{GRP6,                1'b0, 1'b0, 1'b1, 2'd0, 4'd8}, // R8 empty table
    '{48'h0300_0000_0000,  1'b0, 1'b1, 1'b0, 2'd0, 4'd6}, // R6 group bit set
    '{48'h0200_0000_0000,  1'b0, 1'b1, 1'b0, 2'd3, 4'd6}, // R6 group bit clear
    '{48'h8000_0000_0001,  1'b0, 1'b1, 1'b1, 2'd3, 4'd6}, // R6 top bit only
    '{STA,                 1'b0, 1'b1, 1'b1, 2'd0, 4'd5}  // R5 hit with group modes on
  };

  logic        clk, rst_n, bv, pr, am, hm, done, acc;
  logic [7:0]  bt;
  logic [63:0] tbl;
  logic [47:0] sta;
  int          n_chk = 0, n_fail = 0;

  mcast_hash_filter dut (
    .clk_i(clk), .rst_ni(rst_n), .byte_valid_i(bv), .byte_i(bt),
    .promisc_i(pr), .all_mcast_i(am), .hash_mcast_i(hm),
    .hash_table_i(tbl), .station_addr_i(sta),
    .done_o(done), .accept_o(acc)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [5:0] ref_bin(input logic [47:0] a);
    logic [31:0] r = '1;
    logic        fb;
    for (int k = 0; k < 48; k++) begin
      fb = r[31] ^ a[40 - 8 * (k / 8) + (k % 8)];
      r  = fb ? ((r << 1) ^ POLY) : (r << 1);
    end
    return r[31:26];
  endfunction

  function automatic logic ref_acc(input logic [47:0] a, input logic p,
                                   input logic m, input logic h,
                                   input logic [63:0] t, input logic [47:0] s);
    if (p || a == BC) return 1'b1;
    if (a[40])        return m || (h && t[ref_bin(a)]);
    return a == s;
  endfunction

  function automatic logic [63:0] mk_tbl(input logic [47:0] a, input logic [1:0] sel);
    logic [63:0] one = 64'd1 << ref_bin(a);
    case (sel)
      2'd0:    return '0;
      2'd1:    return one;
      2'd2:    return ~one;
      default: return '1;
    endcase
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // drives the six bytes, gap idle cycles between bytes with junk on byte_i
  task automatic send(input logic [47:0] a, input int gap);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      bv = 1'b1;
      bt = a[47 - 8 * i -: 8];
      if (i < 5) begin
        for (int g = 0; g < gap; g++) begin
          @(negedge clk);
          bv = 1'b0;
          bt = 8'hA5 ^ 8'(g);
        end
      end
    end
    @(negedge clk);
    bv = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic exp;
    rst_n = 1'b0; bv = 1'b0; bt = '0; pr = 1'b0; am = 1'b0; hm = 1'b0;
    tbl = '0; sta = STA;
    #1;
    check("R1 done in reset", done, 1'b0);
    check("R1 accept in reset", acc, 1'b0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 done after reset", done, 1'b0);
    check("R1 accept after reset", acc, 1'b0);

    for (int v = 0; v < NV; v++) begin
      pr = VECS[v].pr; am = VECS[v].am; hm = VECS[v].hm;
      tbl = mk_tbl(VECS[v].addr, VECS[v].tsel);
      exp = ref_acc(VECS[v].addr, pr, am, hm, tbl, sta);
      send(VECS[v].addr, 0);
      check($sformatf("R2 done vec %0d", v), done, 1'b1);
      check($sformatf("R%0d accept vec %0d", VECS[v].req, v), acc, exp);
    end

    // R2: single-cycle pulse; R10: hold across idle
    pr = 1'b0; am = 1'b0; hm = 1'b0; tbl = '0;
    send(STA, 0);
    check("R2 done pulse", done, 1'b1);
    @(negedge clk);
    check("R2 done drops", done, 1'b0);
    bt = 8'hFF;
    repeat (4) @(negedge clk);
    check("R10 accept held", acc, 1'b1);
    check("R2 no done while idle", done, 1'b0);

    // R2: gaps with junk bytes ignored
    send(STA, 3);
    check("R2 gapped done", done, 1'b1);
    check("R2 gapped accept", acc, 1'b1);
    send(48'h0250_A1B2_C3D5, 2);
    check("R2 gapped miss", acc, 1'b0);

    // R2: reset discards partial address
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); bv = 1'b1; bt = 8'h77;
    end
    @(negedge clk); bv = 1'b0; rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    send(STA, 0);
    check("R2 after partial reset", acc, 1'b1);

    // R11: only sixth-byte cycle controls matter
    sta = STA;
    pr = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); bv = 1'b1; bt = GRP[47 - 8 * i -: 8];
      if (i == 5) pr = 1'b0;
    end
    @(negedge clk); bv = 1'b0; pr = 1'b1;
    check("R11 earlier promisc ignored", acc, 1'b0);
    pr = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); bv = 1'b1; bt = GRP[47 - 8 * i -: 8];
      hm = (i == 5);
      tbl = (i == 5) ? mk_tbl(GRP, 2'd1) : '0;
    end
    @(negedge clk); bv = 1'b0; hm = 1'b0; tbl = '0;
    check("R11 table at sixth byte", acc, 1'b1);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); bv = 1'b1; bt = STA[47 - 8 * i -: 8];
      sta = (i == 5) ? 48'h0 : STA;
    end
    @(negedge clk); bv = 1'b0; sta = STA;
    check("R11 station at sixth byte", acc, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule